// File: doc/BRIEF.md
# Potential Update Resolution Controller

This block follows a single speculative update that a processor sends out alongside a line read. It then decides when the store waiting on that line may retire. Until the read data returns, the speculative update counts as never issued: it cannot be cancelled and nobody acknowledges it. The state of the returned line settles it. A shared line turns the update into a real one that can be cancelled and must be acknowledged. An exclusive line voids it: the external agent is told to drop it and the store retires at once.

The controller also watches the handshake for misuse and keeps a sticky flag when it sees any. Misuse is an acknowledge or error arriving when no real update is outstanding, or a cancellation arriving while the read is still in flight. All outputs come from registers, so each one reacts in the cycle after the input that caused it.

Top module: `pupd_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are low after that edge, and the block is idle with no read pending.
- R2: A `pu_issue` pulse while idle or resolved starts tracking: a read is now pending and the update is speculative. While it stays speculative, `ack_pending`, `store_done` and `discard_update` stay low.
- R3: A read response with `rd_rsp_line` equal to 2 (shared) or 3 (dirty shared) makes the update compulsory: `ack_pending` is high from the next cycle.
- R4: A read response with `rd_rsp_line` equal to 0 (clean exclusive) or 1 (dirty exclusive) voids the update. In the next cycle `discard_update` and `store_done` both pulse for one cycle, and `ack_pending` stays low.
- R5: `upd_ack` while compulsory gives a one-cycle `store_done` pulse in the next cycle and clears `ack_pending`. `store_err` stays low.
- R6: `upd_err` while compulsory resolves the update like an acknowledge, but `store_err` pulses together with `store_done`.
- R7: `upd_cancel` while compulsory returns the block to idle and pulses `retry_store` in the next cycle, with no `store_done`.
- R8: `upd_ack` or `upd_err` arriving while the update is not compulsory sets `proto_err` from the next cycle. `proto_err` then stays high until reset.
- R9: `upd_cancel` while a read is pending sets `proto_err` and leaves the tracking state unchanged; a later response still resolves normally.
- R10: `upd_cancel` while idle or resolved has no effect on any output.
- R11: A read response with no read pending is ignored. So is `pu_issue` while an update is pending or compulsory.
- R12: When `upd_cancel` and `upd_ack` arrive in the same compulsory cycle, the cancellation wins: `retry_store` pulses, with no `store_done` and no `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pu_issue | input | 1 | Speculative update sent with a line read |
| rd_rsp_valid | input | 1 | Read response strobe |
| rd_rsp_line | input | 2 | Returned line state: 0 clean excl, 1 dirty excl, 2 shared, 3 dirty shared |
| upd_ack | input | 1 | Update acknowledge strobe |
| upd_err | input | 1 | Update error strobe |
| upd_cancel | input | 1 | External update cancellation strobe |
| store_done | output | 1 | Pulse: pending store may complete |
| store_err | output | 1 | Pulse with store_done when the update ended in error |
| ack_pending | output | 1 | A compulsory update awaits acknowledge |
| discard_update | output | 1 | Pulse: agent must drop the voided update |
| retry_store | output | 1 | Pulse: compulsory update was cancelled, store must retry |
| proto_err | output | 1 | Sticky handshake misuse flag |

## Verification
If the tracking state is wrong, the ports show it within one cycle of the next stimulus. A missed promotion leaves `ack_pending` low after a shared response. A missed voiding gives no `discard_update`/`store_done` pair. A stale state turns a legal acknowledge or cancellation into a `proto_err`, or keeps a misuse from setting it. The bench runs a behavioural model next to the design and compares every output on every cycle, so such a fault shows up at the first cycle where the two disagree.

// File: rtl/pupd_pkg.sv
package pupd_pkg;

  localparam int LINE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POT  = 2'd1,
    ST_COMP = 2'd2,
    ST_DONE = 2'd3
  } pu_state_e;

  typedef enum logic [LINE_W-1:0] {
    LN_CLEAN_EXCL   = 2'd0,
    LN_DIRTY_EXCL   = 2'd1,
    LN_SHARED       = 2'd2,
    LN_DIRTY_SHARED = 2'd3
  } line_state_e;

  // Upper bit marks the shared family of returned states.
  function automatic logic line_is_shared(input logic [LINE_W-1:0] ln);
    return ln[LINE_W-1];
  endfunction

endpackage

// File: rtl/pupd_fsm.sv
module pupd_fsm
  import pupd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              rsp_valid,
  input  logic [LINE_W-1:0] rsp_line,
  input  logic              ack,
  input  logic              err,
  input  logic              cancel,
  output pu_state_e         state_q,
  output logic              store_done_q,
  output logic              store_err_q,
  output logic              discard_q,
  output logic              retry_q,
  output logic              ack_wait_q
);

  pu_state_e state_d;
  logic      done_d, serr_d, disc_d, retry_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    serr_d  = 1'b0;
    disc_d  = 1'b0;
    retry_d = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (issue) state_d = ST_POT;
      end
      ST_POT: begin
        if (rsp_valid) begin
          if (line_is_shared(rsp_line)) begin
            state_d = ST_COMP;
          end else begin
            state_d = ST_DONE;
            done_d  = 1'b1;
            disc_d  = 1'b1;
          end
        end
      end
      ST_COMP: begin
        if (cancel) begin
          state_d = ST_IDLE;
          retry_d = 1'b1;
        end else if (ack || err) begin
          state_d = ST_DONE;
          done_d  = 1'b1;
          serr_d  = err;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      store_done_q <= 1'b0;
      store_err_q  <= 1'b0;
      discard_q    <= 1'b0;
      retry_q      <= 1'b0;
      ack_wait_q   <= 1'b0;
    end else begin
      state_q      <= state_d;
      store_done_q <= done_d;
      store_err_q  <= serr_d;
      discard_q    <= disc_d;
      retry_q      <= retry_d;
      ack_wait_q   <= (state_d == ST_COMP);
    end
  end

  // R3: shared return promotes the update
  a_r3_shared_promotes: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_POT && rsp_valid && rsp_line[LINE_W-1]) |=> ack_wait_q && !store_done_q);

  // R4: exclusive return voids the update and frees the store
  a_r4_excl_voids: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_POT && rsp_valid && !rsp_line[LINE_W-1]) |=> discard_q && store_done_q && !ack_wait_q);

  // R5 / R6: acknowledge or error finishes a compulsory update
  a_r5_ack_finishes: assert property (@(posedge clk) disable iff (rst)
    (ack_wait_q && !cancel && (ack || err)) |=> store_done_q && !ack_wait_q);

  // R7: cancellation yields retry and never completion
  a_r7_retry_not_done: assert property (@(posedge clk) disable iff (rst)
    $onehot0({retry_q, store_done_q}));

  // R6: error pulse only together with completion
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (rst)
    store_err_q |-> store_done_q);

endmodule

// File: rtl/pupd_viol.sv
module pupd_viol
  import pupd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pu_state_e state_q,
  input  logic      ack,
  input  logic      err,
  input  logic      cancel,
  output logic      proto_err_q
);

  logic stray_resp, early_cancel;

  assign stray_resp   = (ack || err) && (state_q != ST_COMP);
  assign early_cancel = cancel && (state_q == ST_POT);

  always_ff @(posedge clk) begin
    if (rst) proto_err_q <= 1'b0;
    else if (stray_resp || early_cancel) proto_err_q <= 1'b1;
  end

  // R8: flag never clears without reset
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    proto_err_q |=> proto_err_q);

  // R8: stray acknowledge or error is flagged
  a_r8_stray_flagged: assert property (@(posedge clk) disable iff (rst)
    ((ack || err) && state_q != ST_COMP) |=> proto_err_q);

  // R9: cancellation during a pending read is flagged
  a_r9_early_cancel: assert property (@(posedge clk) disable iff (rst)
    (cancel && state_q == ST_POT) |=> proto_err_q);

endmodule

// File: rtl/pupd_resolver.sv
module pupd_resolver
  import pupd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pu_issue,
  input  logic              rd_rsp_valid,
  input  logic [LINE_W-1:0] rd_rsp_line,
  input  logic              upd_ack,
  input  logic              upd_err,
  input  logic              upd_cancel,
  output logic              store_done,
  output logic              store_err,
  output logic              ack_pending,
  output logic              discard_update,
  output logic              retry_store,
  output logic              proto_err
);

  pu_state_e trk_state;

  pupd_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .issue        (pu_issue),
    .rsp_valid    (rd_rsp_valid),
    .rsp_line     (rd_rsp_line),
    .ack          (upd_ack),
    .err          (upd_err),
    .cancel       (upd_cancel),
    .state_q      (trk_state),
    .store_done_q (store_done),
    .store_err_q  (store_err),
    .discard_q    (discard_update),
    .retry_q      (retry_store),
    .ack_wait_q   (ack_pending)
  );

  pupd_viol u_viol (
    .clk         (clk),
    .rst         (rst),
    .state_q     (trk_state),
    .ack         (upd_ack),
    .err         (upd_err),
    .cancel      (upd_cancel),
    .proto_err_q (proto_err)
  );

  // R10: no retry without a compulsory update in the previous cycle
  a_r10_retry_needs_comp: assert property (@(posedge clk) disable iff (rst)
    (!ack_pending) |=> !retry_store);

endmodule

// File: tb/pupd_resolver_bench.sv
module pupd_resolver_bench;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pu_issue = 0, rd_rsp_valid = 0, upd_ack = 0, upd_err = 0, upd_cancel = 0;
  logic [1:0] rd_rsp_line = 2'd0;
  logic store_done, store_err, ack_pending, discard_update, retry_store, proto_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  pupd_resolver u_pupd_resolver (
    .clk(clk), .rst(rst), .pu_issue(pu_issue), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_line(rd_rsp_line), .upd_ack(upd_ack), .upd_err(upd_err),
    .upd_cancel(upd_cancel), .store_done(store_done), .store_err(store_err),
    .ack_pending(ack_pending), .discard_update(discard_update),
    .retry_store(retry_store), .proto_err(proto_err)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural model: 0 idle, 1 read pending, 2 compulsory, 3 resolved
  int  m_phase = 0;
  bit  m_perr = 0;
  bit  e_done, e_serr, e_disc, e_retry, e_wait;

  task automatic compare(string tag);
    bit bad = 0;
    n_cmp++;
    if (store_done !== e_done) begin bad = 1; $display("FAIL %s store_done got %0b exp %0b", tag, store_done, e_done); end
    if (store_err !== e_serr) begin bad = 1; $display("FAIL %s store_err got %0b exp %0b", tag, store_err, e_serr); end
    if (discard_update !== e_disc) begin bad = 1; $display("FAIL %s discard_update got %0b exp %0b", tag, discard_update, e_disc); end
    if (retry_store !== e_retry) begin bad = 1; $display("FAIL %s retry_store got %0b exp %0b", tag, retry_store, e_retry); end
    if (ack_pending !== e_wait) begin bad = 1; $display("FAIL %s ack_pending got %0b exp %0b", tag, ack_pending, e_wait); end
    if (proto_err !== m_perr) begin bad = 1; $display("FAIL %s proto_err got %0b exp %0b", tag, proto_err, m_perr); end
    if (bad) n_bad++;
  endtask

  task automatic do_reset(string tag);
    rst = 1; pu_issue = 0; rd_rsp_valid = 0; upd_ack = 0; upd_err = 0; upd_cancel = 0;
    m_phase = 0; m_perr = 0;
    {e_done, e_serr, e_disc, e_retry, e_wait} = '0;
    @(negedge clk); @(negedge clk);
    compare(tag);
    rst = 0;
  endtask

  task automatic step(string tag, bit iss, bit rv, bit [1:0] ln, bit ak, bit er, bit cn);
    pu_issue = iss; rd_rsp_valid = rv; rd_rsp_line = ln;
    upd_ack = ak; upd_err = er; upd_cancel = cn;
    if ((ak || er) && m_phase != 2) m_perr = 1;
    if (cn && m_phase == 1) m_perr = 1;
    {e_done, e_serr, e_disc, e_retry} = '0;
    if (m_phase == 0 || m_phase == 3) begin
      if (iss) m_phase = 1;
    end else if (m_phase == 1) begin
      if (rv) begin
        if (ln >= 2) m_phase = 2;
        else begin m_phase = 3; e_done = 1; e_disc = 1; end
      end
    end else begin
      if (cn) begin m_phase = 0; e_retry = 1; end
      else if (ak || er) begin m_phase = 3; e_done = 1; e_serr = er; end
    end
    e_wait = (m_phase == 2);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 2'd0, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired got hang exp finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset("R1");
    // R2 speculative phase
    step("R2", 1, 0, 2'd0, 0, 0, 0);
    idle("R2", 3);
    // R3 shared response, R5 acknowledge
    step("R3", 0, 1, 2'd2, 0, 0, 0);
    idle("R3", 2);
    step("R5", 0, 0, 2'd0, 1, 0, 0);
    idle("R5", 1);
    // R10 cancel when resolved
    step("R10", 0, 0, 2'd0, 0, 0, 1);
    idle("R10", 1);
    // R4 clean and dirty exclusive
    step("R2", 1, 0, 2'd0, 0, 0, 0);
    step("R4", 0, 1, 2'd0, 0, 0, 0);
    idle("R4", 1);
    step("R2", 1, 0, 2'd0, 0, 0, 0);
    step("R4", 0, 1, 2'd1, 0, 0, 0);
    idle("R4", 1);
    // R3 dirty shared, R6 error
    step("R2", 1, 0, 2'd0, 0, 0, 0);
    step("R3", 0, 1, 2'd3, 0, 0, 0);
    step("R6", 0, 0, 2'd0, 0, 1, 0);
    idle("R6", 1);
    // R7 cancel compulsory, then R11 stray response in idle
    step("R2", 1, 0, 2'd0, 0, 0, 0);
    step("R3", 0, 1, 2'd2, 0, 0, 0);
    step("R7", 0, 0, 2'd0, 0, 0, 1);
    idle("R7", 1);
    step("R11", 0, 1, 2'd2, 0, 0, 0);
    idle("R11", 1);
    step("R10", 0, 0, 2'd0, 0, 0, 1);
    // R11 reissue while busy, R12 cancel and ack together
    step("R2", 1, 0, 2'd0, 0, 0, 0);
    step("R11", 1, 0, 2'd0, 0, 0, 0);
    step("R3", 0, 1, 2'd2, 0, 0, 0);
    step("R11", 1, 1, 2'd0, 0, 0, 0);
    step("R12", 0, 0, 2'd0, 1, 0, 1);
    idle("R12", 2);
    // R9 cancel while read pending
    step("R2", 1, 0, 2'd0, 0, 0, 0);
    step("R9", 0, 0, 2'd0, 0, 0, 1);
    step("R9", 0, 1, 2'd2, 0, 0, 0);
    step("R9", 0, 0, 2'd0, 1, 0, 0);
    idle("R9", 2);
    do_reset("R1");
    // R8 acknowledge after voiding, sticky
    step("R2", 1, 0, 2'd0, 0, 0, 0);
    step("R4", 0, 1, 2'd1, 0, 0, 0);
    step("R8", 0, 0, 2'd0, 1, 0, 0);
    idle("R8", 3);
    do_reset("R1");
    // R8 error while idle, and ack during pending read
    step("R8", 0, 0, 2'd0, 0, 1, 0);
    idle("R8", 1);
    do_reset("R1");
    step("R2", 1, 0, 2'd0, 0, 0, 0);
    step("R8", 0, 0, 2'd0, 1, 0, 0);
    step("R8", 0, 1, 2'd3, 0, 0, 0);
    step("R8", 0, 0, 2'd0, 1, 0, 0);
    idle("R8", 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule